// File: doc/BRIEF.md
# PCI interrupt to ISA IRQ router

This block steers four level-sensitive, active-low PCI interrupt requests onto a vector of sixteen active-high ISA-style IRQ lines. Each request has its own 8-bit route register. The register holds an active-low enable and a 4-bit target code. Only a sparse set of target codes reaches a real IRQ line. Every other code is treated as reserved and drives nothing.

The route registers sit at byte offsets 60h to 63h of a simple register port. Writes are synchronous. Reads are combinational from the address. The steering path from the request pins to the IRQ outputs has no register in it, so an IRQ line follows its request level in the same cycle. When more than one enabled request targets the same line, that line carries the OR of them.

Top module: `pirq_router`

## Requirements
- R1: There are four request inputs, 0 to 3, with route registers at offsets 60h, 61h, 62h and 63h in that order. A write with `reg_wr_en` high takes effect at the rising clock edge. `reg_rdata` returns all 8 bits of the addressed register combinationally.
- R2: A synchronous active-high reset sets every route register to 80h, so `irq` is all zero after reset.
- R3: Bit 7 of a route register set to 1 disables that request, and it then drives no IRQ line. Bit 7 set to 0 enables routing.
- R4: Target codes in bits 3:0 of 3 to 7, 9 to 12, 14 and 15 route an enabled, asserted request to the `irq` bit whose index equals the code. This happens in the same cycle, and each request drives at most one line.
- R5: Target codes 0, 1, 2, 8 and 13 are reserved and route nowhere. As a result, `irq` bits 0, 1, 2, 8 and 13 are never driven high.
- R6: When several enabled, asserted requests target one line, that line is the OR of them.
- R7: Bits 6:4 are stored and read back, but they have no effect on routing.
- R8: Writes to offsets outside 60h to 63h change no register, and reads of those offsets return 00h.
- R9: Requests are level sensitive and active low. An IRQ line drops in the same cycle that its last driving request returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pirq_n | input | 4 | PCI interrupt requests, active low |
| irq | output | 16 | ISA-style IRQ outputs, active high |

## Verification
A corrupted route register shows up on `reg_rdata` as soon as its offset is addressed. It also shows up on `irq` in the same cycle as any request that uses that register. A wrong target decode or a leaked reserved code shows as a wrong or extra `irq` bit while the request is low. A stuck enable shows as a line that stays dark or stays lit across the request level. A mis-decoded offset shows as a neighbouring register that changes, or as non-zero read data outside 60h to 63h.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;
    localparam int NUM_REQ = 4;
    localparam int CODE_W  = 4;
    localparam int NUM_IRQ = 1 << CODE_W;
    localparam int ADDR_W  = 8;
    localparam int REG_W   = 8;
    localparam logic [ADDR_W-1:0] ROUTE_BASE = 8'h60;
    localparam logic [REG_W-1:0]  ROUTE_RST  = 8'h80;

    typedef struct packed {
        logic              off;    // 1 = routing disabled
        logic [2:0]        spare;  // stored only
        logic [CODE_W-1:0] code;   // target line
    } route_reg_t;

    function automatic logic code_legal(input logic [CODE_W-1:0] c);
        case (c)
            4'd0, 4'd1, 4'd2, 4'd8, 4'd13: code_legal = 1'b0;
            default:                       code_legal = 1'b1;
        endcase
    endfunction

    function automatic logic [NUM_IRQ-1:0] code_onehot(input logic [CODE_W-1:0] c);
        code_onehot = code_legal(c) ? (NUM_IRQ'(1) << c) : '0;
    endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_route_pkg::*;
#(
    parameter int NUM = NUM_REQ,
    parameter logic [ADDR_W-1:0] BASE = ROUTE_BASE
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [REG_W-1:0]       wdata,
    output logic [REG_W-1:0]       rdata,
    output route_reg_t [NUM-1:0]   regs
);
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1;

    logic [ADDR_W-1:0] offs;
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign offs     = addr - BASE;
    assign in_range = (offs < ADDR_W'(NUM));
    assign idx      = offs[IDX_W-1:0];

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= route_reg_t'(ROUTE_RST);
            else if (wr_en && in_range && idx == IDX_W'(g))
                regs[g] <= route_reg_t'(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (in_range)
            rdata = regs[idx];
    end

    // R1: an in-range write is visible in the addressed register next cycle
    p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_range) |=> (regs[$past(idx)] == route_reg_t'($past(wdata))));

    // R8: a foreign write leaves all registers untouched
    p_foreign_write_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_range) |=> (regs == $past(regs)));
endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
    import pirq_route_pkg::*;
#(
    parameter int NUM = NUM_REQ
) (
    input  logic                   clk,
    input  logic                   rst,
    input  route_reg_t [NUM-1:0]   regs,
    input  logic [NUM-1:0]         req_n,
    output logic [NUM_IRQ-1:0]     irq
);
    logic [NUM_IRQ-1:0] hit [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_req
        always_comb begin
            hit[g] = '0;
            if (!req_n[g] && !regs[g].off)
                hit[g] = code_onehot(regs[g].code);
        end

        // R4: a request drives at most one line
        p_one_target_r4: assert property (@(posedge clk) disable iff (rst)
            $onehot0(hit[g]));
        // R3: disabled register drives nothing
        p_off_silent_r3: assert property (@(posedge clk) disable iff (rst)
            regs[g].off |-> (hit[g] == '0));
        // R5: reserved code drives nothing
        p_reserved_silent_r5: assert property (@(posedge clk) disable iff (rst)
            !code_legal(regs[g].code) |-> (hit[g] == '0));
        // R9: an idle request drives nothing
        p_idle_silent_r9: assert property (@(posedge clk) disable iff (rst)
            req_n[g] |-> (hit[g] == '0));
    end

    always_comb begin
        irq = '0;
        for (int i = 0; i < NUM; i++)
            irq = irq | hit[i];
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_REQ-1:0] pirq_n,
    output logic [NUM_IRQ-1:0] irq
);
    route_reg_t [NUM_REQ-1:0] route;

    pirq_route_regs #(.NUM(NUM_REQ), .BASE(ROUTE_BASE)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .regs  (route)
    );

    pirq_steer #(.NUM(NUM_REQ)) u_steer (
        .clk   (clk),
        .rst   (rst),
        .regs  (route),
        .req_n (pirq_n),
        .irq   (irq)
    );

    // R5: reserved line positions stay low
    p_reserved_lines_low_r5: assert property (@(posedge clk) disable iff (rst)
        !(irq[0] | irq[1] | irq[2] | irq[8] | irq[13]));

    // R2: the first cycle after reset has no line asserted
    p_reset_idle_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq == '0));
endmodule

// File: tb/pirq_router_bench.sv
`timescale 1ns/1ps
module pirq_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [3:0]  pirq_n = 4'hF;
    logic [15:0] irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pirq_router u_pirq_router (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pirq_n(pirq_n), .irq(irq)
    );

    // cfg = {reg63, reg62, reg61, reg60}, req_n, expected irq
    typedef struct packed {
        logic [31:0] cfg;
        logic [3:0]  req_n;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h80808080, 4'b0000, 16'h0000},  // R3 all disabled
        '{32'h80808003, 4'b1110, 16'h0008},  // R4 code 3
        '{32'h090C0E0F, 4'b0000, 16'hD200},  // R4 15,14,12,9
        '{32'h090C0E0F, 4'b1010, 16'h9000},  // R9 req0, req2 only
        '{32'h05050505, 4'b0111, 16'h0020},  // R6 one of shared
        '{32'h05050505, 4'b0000, 16'h0020},  // R6 all shared
        '{32'h0D0B8A0A, 4'b0000, 16'h0C00},  // R3/R5 disabled, reserved
        '{32'h06083477, 4'b0000, 16'h00D0},  // R7 spare bits set
        '{32'h06083477, 4'b1111, 16'h0000}   // R9 all idle
    };

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        check(reg_rdata == exp, tag, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    function automatic logic [15:0] model_line(input logic [3:0] c);
        case (c)
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd9, 4'd10,
            4'd11, 4'd12, 4'd14, 4'd15: model_line = 16'h1 << c;
            default: model_line = 16'h0000;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset defaults
        for (int i = 0; i < 4; i++) rd_check(8'h60 + 8'(i), 8'h80, "R2 reset value");
        pirq_n = 4'h0;
        #0.5;
        check(irq == 16'h0, "R2 irq idle after reset", irq, 16'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            pirq_n = 4'hF;
            for (int i = 0; i < 4; i++) wr(8'h60 + 8'(i), VECS[v].cfg[8*i +: 8]);
            @(negedge clk);
            pirq_n = VECS[v].req_n;
            #0.5;
            check(irq == VECS[v].exp, "R4/R6 table vector", irq, VECS[v].exp);
        end

        // R1 and R7: full byte read-back, including spare bits
        rd_check(8'h60, 8'h77, "R1 R7 readback 60h");
        rd_check(8'h61, 8'h34, "R1 R7 readback 61h");
        rd_check(8'h63, 8'h06, "R1 readback 63h");

        // R8: foreign offsets
        wr(8'h64, 8'h0F);
        wr(8'h5F, 8'h0F);
        rd_check(8'h64, 8'h00, "R8 read 64h zero");
        rd_check(8'h5F, 8'h00, "R8 read 5Fh zero");
        rd_check(8'h63, 8'h06, "R8 63h unchanged");
        rd_check(8'h60, 8'h77, "R8 60h unchanged");

        // R5: sweep all codes on request 0
        for (int i = 1; i < 4; i++) wr(8'h60 + 8'(i), 8'h80);
        for (int c = 0; c < 16; c++) begin
            pirq_n = 4'b1110;
            wr(8'h60, 8'(c));
            #0.5;
            check(irq == model_line(4'(c)), "R4/R5 code sweep", irq, model_line(4'(c)));
        end

        // R3: setting bit 7 silences an active request
        wr(8'h60, 8'h8F);
        #0.5;
        check(irq == 16'h0, "R3 disable active request", irq, 16'h0);

        // R9: same-cycle level following
        wr(8'h61, 8'h0B);
        @(negedge clk);
        pirq_n = 4'b1101;
        #0.5;
        check(irq == 16'h0800, "R9 assert level", irq, 16'h0800);
        pirq_n = 4'b1111;
        #0.5;
        check(irq == 16'h0000, "R9 release level", irq, 16'h0000);

        // R2: reset clears a live route
        pirq_n = 4'b1101;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check(irq == 16'h0, "R2 reset clears route", irq, 16'h0);
        rd_check(8'h61, 8'h80, "R2 reset value after use");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule